// File: doc/BRIEF.md
# Phase Detector Output Pin Controller

This block compares a divided-down oscillator signal against a reference clock and turns the result into drive for two phase-detector output pins. Both pins are modelled as a data bit plus an output enable, so the pad ring can build a real tri-state buffer. Configuration registers set each pin's behaviour independently. A pin can act as a three-level phase output, stay permanently undriven, serve as a plain output port, or carry one line of a digital pump-up/pump-down pair that drives an external charge pump.

Each pin also presents a two-bit code that selects the analog output resistance. On the second pin this code can be chosen automatically. The block measures the width of every phase-error pulse in system clocks. A wide error picks the lowest resistance so the loop slews fast, and a narrow error picks the highest resistance so it settles quietly near lock.

Both comparison inputs are sampled on the system clock, and only their rising edges count. Configuration is written through a small register port: an address, a data byte and a write strobe.

Top module: `pdo_top`

## Requirements
- R1: After a synchronous reset, both pins have output enable low, both resistance codes read 2 (100k), and automatic selection is off.
- R2: Pin mode 1 gives a three-level output. It drives 1 while the divider leads (UP flag set), drives 0 while the reference leads (DOWN flag set), and has output enable low when neither flag is set.
- R3: Pin mode 3 drives the pump-up line and pin mode 4 drives the pump-down line. Both are always enabled. Together the pair reads 1/0 when the divider leads, 0/1 when the reference leads, and 0/0 when neither flag is set.
- R4: Pin modes 0, 5, 6 and 7 keep output enable low whatever the phase state.
- R5: Pin mode 2 enables the pin and drives the programmed port bit whatever the phase state.
- R6: A rising edge on the divider input sets UP, and a rising edge on the reference input sets DOWN. When both would be set, both clear in that same cycle, so UP and DOWN are never high together. Rises on both inputs in one cycle produce no pulse.
- R7: If the reference rises N clocks after the divider, the phase output is driven high for exactly N clocks. The mirror case, with the reference leading, gives the same width.
- R8: Each pin's manual resistance code is the written value of bits [5:4] of its configuration byte (0 = 5k, 1 = 50k, 2 = 100k). A written 3 is stored as 2.
- R9: With automatic selection on, the second pin's code becomes 0 after an error pulse wider than the threshold, and becomes 2 after one no wider. The code updates one clock after the pulse ends and holds in between. The first pin always uses its manual code, and turning automatic selection off restores the manual code.
- R10: Register map. Address 0 is the first pin's configuration and address 1 is the second pin's. In a configuration byte, bits [2:0] are the mode, bit 3 is the port bit and bits [5:4] are the resistance. Address 2 bit 0 enables automatic selection, and address 3 holds the pulse-width threshold. Writes to addresses 4 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Reference clock, sampled on clk |
| div_in | input | 1 | Divided oscillator signal, sampled on clk |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| pd_a_do | output | 1 | First pin data |
| pd_a_oe | output | 1 | First pin output enable |
| pd_b_do | output | 1 | Second pin data |
| pd_b_oe | output | 1 | Second pin output enable |
| res_a | output | 2 | First pin resistance select |
| res_b | output | 2 | Second pin resistance select |

## Verification
Two functions can coincide in a single cycle. The first case is both comparison inputs rising on the same clock: the bench drives both edges together and then confirms that no phase pulse ever reaches the pin. The second case is a configuration write landing while an error pulse is still active: the bench rewrites the first pin from phase mode to port mode in the middle of a pulse, and expects the port value on the very next cycle even though the UP flag is still set.

// File: rtl/pdo_pkg.sv
package pdo_pkg;

    // Resistance select codes
    localparam logic [1:0] RES_5K   = 2'd0;
    localparam logic [1:0] RES_50K  = 2'd1;
    localparam logic [1:0] RES_100K = 2'd2;

    // Pin mode codes
    localparam logic [2:0] PM_HIZ    = 3'd0;
    localparam logic [2:0] PM_PHASE  = 3'd1;
    localparam logic [2:0] PM_PORT   = 3'd2;
    localparam logic [2:0] PM_PUMP_P = 3'd3;
    localparam logic [2:0] PM_PUMP_N = 3'd4;

    // Per-pin configuration, bit layout matches the written byte [5:0]
    typedef struct packed {
        logic [1:0] res;
        logic       port_val;
        logic [2:0] mode;
    } pin_cfg_t;

    localparam pin_cfg_t PIN_CFG_RESET = '{res: RES_100K, port_val: 1'b0, mode: PM_HIZ};

    typedef struct packed {
        logic up;
        logic dn;
    } phase_t;

    typedef struct packed {
        logic oe;
        logic dat;
    } pin_drv_t;

    function automatic logic [1:0] clamp_res(input logic [1:0] code);
        return (code == 2'd3) ? RES_100K : code;
    endfunction

    function automatic pin_drv_t drive_pin(input pin_cfg_t cfg, input phase_t ph);
        pin_drv_t d;
        d = '{oe: 1'b0, dat: 1'b0};
        case (cfg.mode)
            PM_PHASE:  d = '{oe: ph.up | ph.dn, dat: ph.up};
            PM_PORT:   d = '{oe: 1'b1, dat: cfg.port_val};
            PM_PUMP_P: d = '{oe: 1'b1, dat: ph.up};
            PM_PUMP_N: d = '{oe: 1'b1, dat: ph.dn};
            default:   d = '{oe: 1'b0, dat: 1'b0};
        endcase
        return d;
    endfunction

endpackage

// File: rtl/pdo_regs.sv
module pdo_regs
    import pdo_pkg::*;
#(
    parameter int ADDR_W   = 3,
    parameter int DATA_W   = 8,
    parameter int CNT_W    = 8,
    parameter int THR_INIT = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output pin_cfg_t          cfg_a,
    output pin_cfg_t          cfg_b,
    output logic              auto_en,
    output logic [CNT_W-1:0]  thr
);
    localparam logic [ADDR_W-1:0] A_PIN_A = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_PIN_B = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_AUTO  = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] A_THR   = ADDR_W'(3);

    pin_cfg_t wr_cfg;
    assign wr_cfg = pin_cfg_t'({clamp_res(wr_data[5:4]), wr_data[3:0]});

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_a   <= PIN_CFG_RESET;
            cfg_b   <= PIN_CFG_RESET;
            auto_en <= 1'b0;
            thr     <= CNT_W'(THR_INIT);
        end else if (wr_en) begin
            case (wr_addr)
                A_PIN_A: cfg_a   <= wr_cfg;
                A_PIN_B: cfg_b   <= wr_cfg;
                A_AUTO:  auto_en <= wr_data[0];
                A_THR:   thr     <= wr_data[CNT_W-1:0];
                default: ;
            endcase
        end
    end

    assert_res_legal_R8: assert property (@(posedge clk) disable iff (rst)
        (cfg_a.res != 2'd3) && (cfg_b.res != 2'd3));

endmodule

// File: rtl/pdo_pfd.sv
module pdo_pfd
    import pdo_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   ref_in,
    input  logic   div_in,
    output phase_t ph
);
    logic ref_q, div_q;
    logic ref_rise, div_rise;
    phase_t nxt;

    assign ref_rise = ref_in & ~ref_q;
    assign div_rise = div_in & ~div_q;

    always_comb begin
        nxt.up = ph.up | div_rise;
        nxt.dn = ph.dn | ref_rise;
        if (nxt.up && nxt.dn) begin
            nxt = '{up: 1'b0, dn: 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q <= 1'b0;
            div_q <= 1'b0;
            ph    <= '{up: 1'b0, dn: 1'b0};
        end else begin
            ref_q <= ref_in;
            div_q <= div_in;
            ph    <= nxt;
        end
    end

    assert_flags_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
        !(ph.up && ph.dn));

    assert_up_from_div_edge_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(ph.up) |-> $past(div_rise));

    assert_dn_from_ref_edge_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(ph.dn) |-> $past(ref_rise));

endmodule

// File: rtl/pdo_autores.sv
module pdo_autores
    import pdo_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  phase_t           ph,
    input  logic [CNT_W-1:0] thr,
    output logic [1:0]       auto_code
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] width;
    logic active, act_q, pulse_end;

    assign active    = ph.up | ph.dn;
    assign pulse_end = act_q & ~active;

    always_ff @(posedge clk) begin
        if (rst) begin
            width     <= '0;
            act_q     <= 1'b0;
            auto_code <= RES_100K;
        end else begin
            act_q <= active;
            if (active) begin
                if (width != CNT_MAX) width <= width + 1'b1;
            end else begin
                width <= '0;
            end
            if (pulse_end) begin
                auto_code <= (width > thr) ? RES_5K : RES_100K;
            end
        end
    end

    assert_code_holds_R9: assert property (@(posedge clk) disable iff (rst)
        !pulse_end |=> $stable(auto_code));

    assert_code_legal_R9: assert property (@(posedge clk) disable iff (rst)
        (auto_code == RES_5K) || (auto_code == RES_100K));

endmodule

// File: rtl/pdo_top.sv
module pdo_top
    import pdo_pkg::*;
#(
    parameter int ADDR_W   = 3,
    parameter int DATA_W   = 8,
    parameter int CNT_W    = 8,
    parameter int THR_INIT = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_in,
    input  logic              div_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              pd_a_do,
    output logic              pd_a_oe,
    output logic              pd_b_do,
    output logic              pd_b_oe,
    output logic [1:0]        res_a,
    output logic [1:0]        res_b
);
    pin_cfg_t         cfg_a, cfg_b;
    logic             auto_en;
    logic [CNT_W-1:0] thr;
    phase_t           ph;
    logic [1:0]       auto_code;
    pin_drv_t         drv_a, drv_b;

    pdo_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .THR_INIT(THR_INIT)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cfg_a(cfg_a), .cfg_b(cfg_b), .auto_en(auto_en), .thr(thr)
    );

    pdo_pfd u_pfd (
        .clk(clk), .rst(rst), .ref_in(ref_in), .div_in(div_in), .ph(ph)
    );

    pdo_autores #(.CNT_W(CNT_W)) u_autores (
        .clk(clk), .rst(rst), .ph(ph), .thr(thr), .auto_code(auto_code)
    );

    assign drv_a   = drive_pin(cfg_a, ph);
    assign drv_b   = drive_pin(cfg_b, ph);
    assign pd_a_do = drv_a.dat;
    assign pd_a_oe = drv_a.oe;
    assign pd_b_do = drv_b.dat;
    assign pd_b_oe = drv_b.oe;
    assign res_a   = cfg_a.res;
    assign res_b   = auto_en ? auto_code : cfg_b.res;

    assert_pump_pair_R3: assert property (@(posedge clk) disable iff (rst)
        (cfg_a.mode == PM_PUMP_P && cfg_b.mode == PM_PUMP_N) |-> !(pd_a_do && pd_b_do));

    assert_hiz_pin_R4: assert property (@(posedge clk) disable iff (rst)
        (cfg_a.mode == PM_HIZ) |-> !pd_a_oe);

    assert_port_drive_R5: assert property (@(posedge clk) disable iff (rst)
        (cfg_b.mode == PM_PORT) |-> (pd_b_oe && pd_b_do == cfg_b.port_val));

    assert_phase_float_R2: assert property (@(posedge clk) disable iff (rst)
        (cfg_a.mode == PM_PHASE && !ph.up && !ph.dn) |-> !pd_a_oe);

endmodule

// File: tb/pdo_top_bench.sv
module pdo_top_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_in = 1'b0, div_in = 1'b0;
    logic wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic pd_a_do, pd_a_oe, pd_b_do, pd_b_oe;
    logic [1:0] res_a, res_b;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    pdo_top u_pdo_top (
        .clk(clk), .rst(rst), .ref_in(ref_in), .div_in(div_in),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pd_a_do(pd_a_do), .pd_a_oe(pd_a_oe), .pd_b_do(pd_b_do), .pd_b_oe(pd_b_oe),
        .res_a(res_a), .res_b(res_b)
    );

    // vector: [7:5] mode, [4] port bit, [3:2] state (0 idle,1 up,2 dn), [1] oe, [0] data
    localparam int NV = 15;
    localparam logic [7:0] VEC [NV] = '{
        {3'd1, 1'b0, 2'd0, 1'b0, 1'b0},
        {3'd1, 1'b0, 2'd1, 1'b1, 1'b1},
        {3'd1, 1'b0, 2'd2, 1'b1, 1'b0},
        {3'd0, 1'b0, 2'd1, 1'b0, 1'b0},
        {3'd0, 1'b1, 2'd2, 1'b0, 1'b0},
        {3'd2, 1'b1, 2'd1, 1'b1, 1'b1},
        {3'd2, 1'b0, 2'd2, 1'b1, 1'b0},
        {3'd2, 1'b1, 2'd0, 1'b1, 1'b1},
        {3'd3, 1'b0, 2'd1, 1'b1, 1'b1},
        {3'd3, 1'b0, 2'd2, 1'b1, 1'b0},
        {3'd3, 1'b0, 2'd0, 1'b1, 1'b0},
        {3'd4, 1'b0, 2'd1, 1'b1, 1'b0},
        {3'd4, 1'b0, 2'd2, 1'b1, 1'b1},
        {3'd4, 1'b0, 2'd0, 1'b1, 1'b0},
        {3'd7, 1'b1, 2'd1, 1'b0, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // leave UP (lead_div=1) or DOWN set, sampled at a negedge
    task automatic set_flag(input bit lead_div);
        @(negedge clk);
        if (lead_div) div_in = 1'b1; else ref_in = 1'b1;
        @(negedge clk);
        div_in = 1'b0; ref_in = 1'b0;
    endtask

    task automatic clear_flag(input bit lead_div);
        if (lead_div) ref_in = 1'b1; else div_in = 1'b1;
        @(negedge clk);
        div_in = 1'b0; ref_in = 1'b0;
    endtask

    // second edge n clocks after the first; counts cycles with first pin enabled
    task automatic run_pulse(input bit lead_div, input int n, output int seen);
        seen = 0;
        @(negedge clk);
        if (lead_div) div_in = 1'b1; else ref_in = 1'b1;
        for (int k = 1; k <= n; k++) begin
            @(negedge clk);
            if (k == 1) begin div_in = 1'b0; ref_in = 1'b0; end
            if (pd_a_oe) seen++;
            if (k == n) begin
                if (lead_div) ref_in = 1'b1; else div_in = 1'b1;
            end
        end
        @(negedge clk);
        div_in = 1'b0; ref_in = 1'b0;
        if (pd_a_oe) seen++;
    endtask

    function automatic string tag_of(input logic [2:0] m);
        case (m)
            3'd1: return "R2";
            3'd2: return "R5";
            3'd3, 3'd4: return "R3";
            default: return "R4";
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int seen;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 a_oe", pd_a_oe, 0);
        chk("R1 b_oe", pd_b_oe, 0);
        chk("R1 res_a", res_a, 2);
        chk("R1 res_b", res_b, 2);

        // vector walk on both pins (R2 R3 R4 R5)
        for (int i = 0; i < NV; i++) begin
            logic [2:0] m;
            logic [1:0] st;
            m  = VEC[i][7:5];
            st = VEC[i][3:2];
            wr(3'd0, {4'b0010, VEC[i][4], m});
            wr(3'd1, {4'b0010, VEC[i][4], m});
            if (st == 2'd0) @(negedge clk);
            else set_flag(st == 2'd1);
            chk({tag_of(m), " a_oe"}, pd_a_oe, VEC[i][1]);
            chk({tag_of(m), " a_do"}, pd_a_oe ? pd_a_do : 1'b0, VEC[i][0]);
            chk({tag_of(m), " b_oe"}, pd_b_oe, VEC[i][1]);
            chk({tag_of(m), " b_do"}, pd_b_oe ? pd_b_do : 1'b0, VEC[i][0]);
            if (st != 2'd0) clear_flag(st == 2'd1);
        end

        // pump pair across pins: a = up line, b = down line (R3)
        wr(3'd0, 8'h23); wr(3'd1, 8'h24);
        set_flag(1'b1);
        chk("R3 pair up", {pd_a_do, pd_b_do}, 2'b10);
        clear_flag(1'b1);
        chk("R3 pair idle", {pd_a_do, pd_b_do}, 2'b00);
        set_flag(1'b0);
        chk("R3 pair dn", {pd_a_do, pd_b_do}, 2'b01);
        clear_flag(1'b0);

        // R6 simultaneous rises give no pulse
        wr(3'd0, 8'h21);
        @(negedge clk);
        div_in = 1'b1; ref_in = 1'b1;
        @(negedge clk);
        div_in = 1'b0; ref_in = 1'b0;
        chk("R6 same-cycle rises", pd_a_oe, 0);
        @(negedge clk);
        chk("R6 still idle", pd_a_oe, 0);

        // R7 pulse widths
        run_pulse(1'b1, 5, seen);
        chk("R7 width up 5", seen, 5);
        run_pulse(1'b0, 3, seen);
        chk("R7 width dn 3", seen, 3);

        // concurrent: mode write during an active pulse
        set_flag(1'b1);
        chk("R2 mid-pulse up", {pd_a_oe, pd_a_do}, 2'b11);
        wr(3'd0, 8'h22);
        chk("R5 write during pulse", {pd_a_oe, pd_a_do}, 2'b10);
        clear_flag(1'b1);

        // R8 manual resistance codes
        wr(3'd0, 8'h02); chk("R8 code0", res_a, 0);
        wr(3'd0, 8'h12); chk("R8 code1", res_a, 1);
        wr(3'd0, 8'h32); chk("R8 code3 clamps", res_a, 2);

        // R9 automatic selection on second pin
        wr(3'd0, 8'h11);          // first pin phase, manual 50k
        wr(3'd1, 8'h11);          // second pin manual 50k
        wr(3'd3, 8'd4);           // threshold 4
        wr(3'd2, 8'h01);
        run_pulse(1'b1, 5, seen);
        @(negedge clk);
        chk("R9 wide -> 5k", res_b, 0);
        chk("R9 first pin manual", res_a, 1);
        run_pulse(1'b1, 4, seen);
        @(negedge clk);
        chk("R9 at threshold -> 100k", res_b, 2);
        run_pulse(1'b0, 6, seen);
        @(negedge clk);
        chk("R9 wide dn -> 5k", res_b, 0);
        repeat (3) @(negedge clk);
        chk("R9 holds", res_b, 0);
        wr(3'd2, 8'h00);
        chk("R9 auto off manual", res_b, 1);

        // R10 unused addresses
        wr(3'd0, 8'h02);
        for (int a = 4; a < 8; a++) wr(3'(a), 8'hFF);
        chk("R10 a pin", {pd_a_oe, pd_a_do}, 2'b10);
        chk("R10 res_a", res_a, 0);
        chk("R10 res_b", res_b, 1);
        chk("R10 b phase idle", pd_b_oe, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule